// File: doc/BRIEF.md
# Field-Masked BCD Alarm Comparator

This block watches the running time and calendar words of a real-time clock and raises an alarm when they agree with two programmed alarm words. The time alarm word holds second, minute and hour values. The calendar alarm word holds month and date values. Each field carries its own enable bit, and only enabled fields take part in the comparison. The calendar alarm has no year or century field, so year and century never affect the result.

The comparison runs once for each one-second tick, after the clock counters have moved to the new second. A successful match sets a sticky alarm flag. The flag stays set until software writes a one to bit 1 of the status-clear command. The interrupt line is the alarm flag gated by a mask bit. Software sets the mask through an enable command and clears it through a disable command. Any write to an alarm word drops an evaluation that is still in flight, so a comparison made against the old alarm values cannot set the flag.

Top module: `bcd_alarm_unit`

## Requirements
- R1: The time alarm word stores seconds in bits 6:0 (enable bit 7), minutes in bits 14:8 (enable bit 15) and hours in bits 21:16 (enable bit 23). A write with wr_sel=0 loads it, and every other bit reads back as zero on talm_o.
- R2: The calendar alarm word stores month in bits 20:16 (enable bit 23) and date in bits 29:24 (enable bit 31). A write with wr_sel=1 loads it, and every other bit reads back as zero on calm_o, including the year and century positions.
- R3: When sec_tick is high at clock edge N and every enabled alarm field equals the matching BCD field of cur_time or cur_cal, alarm_o is 1 after edge N+1. A field whose enable bit is 0 is ignored, and a mismatch in any enabled field keeps alarm_o at 0.
- R4: The comparison is made only on a sec_tick. A matching time with no tick never sets alarm_o, and so one matching second sets the flag at most once.
- R5: If all five enable bits are 0, alarm_o is never set.
- R6: alarm_o stays at 1 until a write with wr_sel=2 and wr_data bit 1 set. Such a write with bit 1 clear has no effect. A set and a clear on the same edge leave the flag set.
- R7: A write with wr_sel=3 and bit 1 set makes mask_o 1. A write with wr_sel=4 and bit 1 set makes mask_o 0.
- R8: irq_o is alarm_o AND mask_o. Clearing the mask drops irq_o but leaves alarm_o unchanged.
- R9: A write to either alarm word (wr_sel 0 or 1) on the edge that carries a tick, or on the edge after it, cancels that tick's evaluation.
- R10: After reset, alarm_o, mask_o, irq_o, talm_o and calm_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse after the counters advance a second |
| cur_time | input | DATA_W | Current BCD time word |
| cur_cal | input | DATA_W | Current BCD calendar word |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Write target: 0 time alarm, 1 calendar alarm, 2 status clear, 3 irq enable, 4 irq disable |
| wr_data | input | DATA_W | Write data |
| talm_o | output | DATA_W | Stored time alarm word |
| calm_o | output | DATA_W | Stored calendar alarm word |
| alarm_o | output | 1 | Sticky alarm flag |
| mask_o | output | 1 | Alarm interrupt mask |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The comparator is tried with a time that matches on every field, a time that is off in one enabled field, and the same miss placed in a disabled field. The pass and fail results separate true field masking from a plain whole-word compare. A matching time held with no tick, and a matching time whose alarm word is rewritten right after the tick, show whether evaluation really waits for the tick and whether a rewrite cancels it. An all-enables-off setup shows that an empty enable set cannot act as "match anything". Clear commands with and without bit 1, and mask toggles while the flag is set, separate the flag state from the interrupt gating.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;

   typedef enum logic [2:0] {
      SEL_TALM = 3'd0,
      SEL_CALM = 3'd1,
      SEL_CLR  = 3'd2,
      SEL_IEN  = 3'd3,
      SEL_IDIS = 3'd4
   } alm_sel_e;

   localparam int NUM_FIELDS = 5;
   localparam int ALARM_BIT  = 1;
   localparam int WORD_MIN_W = 32;

   // field index: 0 sec, 1 min, 2 hour, 3 month, 4 date
   function automatic int fld_lsb(input int i);
      case (i)
         0: return 0;
         1: return 8;
         2: return 16;
         3: return 16;
         default: return 24;
      endcase
   endfunction

   function automatic int fld_width(input int i);
      case (i)
         0: return 7;
         1: return 7;
         2: return 6;
         3: return 5;
         default: return 6;
      endcase
   endfunction

   function automatic int fld_en_pos(input int i);
      case (i)
         0: return 7;
         1: return 15;
         2: return 23;
         3: return 23;
         default: return 31;
      endcase
   endfunction

   function automatic bit fld_in_cal(input int i);
      return (i >= 3);
   endfunction

   // bits a stored alarm word keeps: its fields plus their enables
   function automatic logic [31:0] keep_mask(input bit cal);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < NUM_FIELDS; i++) begin
         if (fld_in_cal(i) == cal) begin
            for (int b = 0; b < fld_width(i); b++)
               m[fld_lsb(i) + b] = 1'b1;
            m[fld_en_pos(i)] = 1'b1;
         end
      end
      return m;
   endfunction

endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
   parameter int W = 7
) (
   input  logic [W-1:0] want,
   input  logic [W-1:0] have,
   input  logic         en,
   output logic         hit
);
   if (W < 1) begin : g_bad_w
      $error("alm_field_cmp: W must be positive");
   end

   always_comb hit = !en || (want == have);
endmodule

// File: rtl/alm_regs.sv
module alm_regs
   import bcd_alarm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] talm_q,
   output logic [DATA_W-1:0] calm_q,
   output logic              mask_q,
   output logic              clr_req,
   output logic              alarm_wr
);
   localparam logic [DATA_W-1:0] TKEEP = DATA_W'(keep_mask(1'b0));
   localparam logic [DATA_W-1:0] CKEEP = DATA_W'(keep_mask(1'b1));

   logic hit_t, hit_c, hit_clr, hit_ien, hit_idis;

   always_comb begin
      hit_t    = wr_en && (wr_sel == SEL_W'(SEL_TALM));
      hit_c    = wr_en && (wr_sel == SEL_W'(SEL_CALM));
      hit_clr  = wr_en && (wr_sel == SEL_W'(SEL_CLR));
      hit_ien  = wr_en && (wr_sel == SEL_W'(SEL_IEN));
      hit_idis = wr_en && (wr_sel == SEL_W'(SEL_IDIS));
      clr_req  = hit_clr && wr_data[ALARM_BIT];
      alarm_wr = hit_t || hit_c;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         talm_q <= '0;
         calm_q <= '0;
         mask_q <= 1'b0;
      end else begin
         if (hit_t) talm_q <= wr_data & TKEEP;
         if (hit_c) calm_q <= wr_data & CKEEP;
         if (hit_ien && wr_data[ALARM_BIT])
            mask_q <= 1'b1;
         else if (hit_idis && wr_data[ALARM_BIT])
            mask_q <= 1'b0;
      end
   end
endmodule

// File: rtl/alm_eval.sv
module alm_eval (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic match,
   input  logic alarm_wr,
   input  logic clr_req,
   output logic flag_q,
   output logic pend_q
);
   logic hit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         hit_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         pend_q <= tick && !alarm_wr;
         hit_q  <= match;
         if (pend_q && hit_q && !alarm_wr)
            flag_q <= 1'b1;
         else if (clr_req)
            flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/bcd_alarm_unit.sv
module bcd_alarm_unit
   import bcd_alarm_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SEL_W   = 3,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic [DATA_W-1:0] cur_time,
   input  logic [DATA_W-1:0] cur_cal,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] talm_o,
   output logic [DATA_W-1:0] calm_o,
   output logic              alarm_o,
   output logic              mask_o,
   output logic              irq_o
);
   if (DATA_W < WORD_MIN_W) begin : g_bad_data
      $error("bcd_alarm_unit: DATA_W below 32");
   end
   if (SEL_W < 3) begin : g_bad_sel
      $error("bcd_alarm_unit: SEL_W below 3");
   end

   logic [DATA_W-1:0]     talm_q, calm_q;
   logic                  mask_q, clr_req, alarm_wr;
   logic                  eval_pend, flag_q, match;
   logic [NUM_FIELDS-1:0] hit_vec, en_vec;

   alm_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .talm_q  (talm_q),
      .calm_q  (calm_q),
      .mask_q  (mask_q),
      .clr_req (clr_req),
      .alarm_wr(alarm_wr)
   );

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
      localparam int LSB = fld_lsb(i);
      localparam int W   = fld_width(i);
      localparam int ENP = fld_en_pos(i);
      logic [W-1:0] want, have;
      logic         en;
      if (fld_in_cal(i)) begin : g_cal
         assign want = calm_q[LSB +: W];
         assign have = cur_cal[LSB +: W];
         assign en   = calm_q[ENP];
      end else begin : g_time
         assign want = talm_q[LSB +: W];
         assign have = cur_time[LSB +: W];
         assign en   = talm_q[ENP];
      end
      alm_field_cmp #(.W(W)) u_cmp (
         .want(want),
         .have(have),
         .en  (en),
         .hit (hit_vec[i])
      );
      assign en_vec[i] = en;
   end

   always_comb match = (|en_vec) && (&hit_vec);

   alm_eval u_eval (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (sec_tick),
      .match   (match),
      .alarm_wr(alarm_wr),
      .clr_req (clr_req),
      .flag_q  (flag_q),
      .pend_q  (eval_pend)
   );

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= flag_q && mask_q;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = flag_q && mask_q;
   end

   assign talm_o  = talm_q;
   assign calm_o  = calm_q;
   assign alarm_o = flag_q;
   assign mask_o  = mask_q;
endmodule

// File: rtl/bcd_alarm_checker.sv
module bcd_alarm_checker
   import bcd_alarm_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SEL_W   = 3,
   parameter bit IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sec_tick,
   input logic              wr_en,
   input logic [SEL_W-1:0]  wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] talm_o,
   input logic [DATA_W-1:0] calm_o,
   input logic              alarm_o,
   input logic              mask_o,
   input logic              irq_o,
   input logic              eval_pend
);
   logic clr_cmd, awr, any_en;
   always_comb begin
      clr_cmd = wr_en && (wr_sel == SEL_W'(SEL_CLR)) && wr_data[ALARM_BIT];
      awr     = wr_en && ((wr_sel == SEL_W'(SEL_TALM)) || (wr_sel == SEL_W'(SEL_CALM)));
      any_en  = talm_o[7] || talm_o[15] || talm_o[23] || calm_o[23] || calm_o[31];
   end

   p_set_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_o) |-> $past(sec_tick, 2));

   p_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_o && !eval_pend) |=> !alarm_o);

   p_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_o) |-> any_en);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_o && !clr_cmd) |=> alarm_o);

   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cmd && !eval_pend) |=> !alarm_o);

   p_mask_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W'(SEL_IEN) && wr_data[ALARM_BIT]) |=> mask_o);

   p_mask_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W'(SEL_IDIS) && wr_data[ALARM_BIT]) |=> !mask_o);

   if (!IRQ_REG) begin : g_irq_chk
      p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(mask_o) |-> !irq_o);
   end

   p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_pend && awr && !alarm_o) |=> !alarm_o);
endmodule

bind bcd_alarm_unit bcd_alarm_checker #(
   .DATA_W(DATA_W), .SEL_W(SEL_W), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sec_tick (sec_tick),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_data  (wr_data),
   .talm_o   (talm_o),
   .calm_o   (calm_o),
   .alarm_o  (alarm_o),
   .mask_o   (mask_o),
   .irq_o    (irq_o),
   .eval_pend(eval_pend)
);

// File: tb/bcd_alarm_unit_test.sv
`timescale 1ns/1ps
module bcd_alarm_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic [31:0] cur_time = '0;
   logic [31:0] cur_cal = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] talm_o, calm_o;
   logic        alarm_o, mask_o, irq_o;
   int          n_tests = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   // alarm words: sec 30, min 15, hour 12, all enabled; month 06, date 21 enabled
   localparam logic [31:0] TALM_ALL = 32'h0092_95B0;
   localparam logic [31:0] CALM_ALL = 32'hA186_0000;
   localparam logic [31:0] T_MATCH  = 32'h0012_1530;
   localparam logic [31:0] C_MATCH  = 32'h2166_2420;

   always #2.5 clk = ~clk;

   bcd_alarm_unit uut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
      .cur_time(cur_time), .cur_cal(cur_cal),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .talm_o(talm_o), .calm_o(calm_o), .alarm_o(alarm_o),
      .mask_o(mask_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick_eval();
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic arm_full();
      wr(3'd0, TALM_ALL);
      wr(3'd1, CALM_ALL);
      wr(3'd2, 32'h2);
   endtask

   task automatic t_reset();
      chk("R10 alarm", {31'b0, alarm_o}, 0);
      chk("R10 mask", {31'b0, mask_o}, 0);
      chk("R10 irq", {31'b0, irq_o}, 0);
      chk("R10 talm", talm_o, 0);
      chk("R10 calm", calm_o, 0);
   endtask

   task automatic t_layout();
      wr(3'd0, 32'hFFFF_FFFF);
      chk("R1 time alarm kept bits", talm_o, 32'h00BF_FFFF);
      wr(3'd1, 32'hFFFF_FFFF);
      chk("R2 calendar alarm kept bits", calm_o, 32'hBF9F_0000);
   endtask

   task automatic t_no_tick();
      arm_full();
      cur_time = T_MATCH; cur_cal = C_MATCH;
      repeat (6) @(negedge clk);
      chk("R4 no tick no flag", {31'b0, alarm_o}, 0);
   endtask

   task automatic t_match();
      tick_eval();
      chk("R3 full match sets flag", {31'b0, alarm_o}, 1);
      cur_time = 32'h0012_1531;
      tick_eval();
      chk("R6 flag holds past mismatch", {31'b0, alarm_o}, 1);
      wr(3'd2, 32'h1);
      chk("R6 clear without bit1 ignored", {31'b0, alarm_o}, 1);
      wr(3'd2, 32'h2);
      chk("R6 clear bit1", {31'b0, alarm_o}, 0);
   endtask

   task automatic t_mask();
      cur_time = T_MATCH;
      wr(3'd3, 32'h2);
      chk("R7 mask set", {31'b0, mask_o}, 1);
      chk("R8 irq low without flag", {31'b0, irq_o}, 0);
      tick_eval();
      chk("R8 irq high", {31'b0, irq_o}, 1);
      wr(3'd4, 32'h2);
      chk("R7 mask cleared", {31'b0, mask_o}, 0);
      chk("R8 irq dropped", {31'b0, irq_o}, 0);
      chk("R8 flag kept", {31'b0, alarm_o}, 1);
      wr(3'd2, 32'h2);
   endtask

   task automatic t_field_mask();
      cur_time = 32'h0012_1531;
      tick_eval();
      chk("R3 enabled mismatch no flag", {31'b0, alarm_o}, 0);
      wr(3'd0, TALM_ALL & ~32'h80);
      tick_eval();
      chk("R3 disabled field ignored", {31'b0, alarm_o}, 1);
      wr(3'd2, 32'h2);
      repeat (4) @(negedge clk);
      chk("R4 one set per second", {31'b0, alarm_o}, 0);
   endtask

   task automatic t_no_enable();
      wr(3'd0, T_MATCH);
      wr(3'd1, 32'h2106_0000);
      cur_time = T_MATCH;
      tick_eval();
      chk("R5 no enables no flag", {31'b0, alarm_o}, 0);
   endtask

   task automatic t_cancel();
      arm_full();
      cur_time = T_MATCH; cur_cal = C_MATCH;
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      wr_en = 1'b1; wr_sel = 3'd0; wr_data = TALM_ALL;
      @(negedge clk); wr_en = 1'b0;
      @(negedge clk);
      chk("R9 rewrite cancels evaluation", {31'b0, alarm_o}, 0);
      tick_eval();
      chk("R9 later tick still fires", {31'b0, alarm_o}, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_layout();
      t_no_tick();
      t_match();
      t_mask();
      t_field_mask();
      t_no_enable();
      t_cancel();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule